// File: doc/BRIEF.md
# Mixed-Width Register Target for a Byte-Level I2C Port

This block is the device side of the control port for a six-channel audio amplifier. A bit engine, outside this block, turns the SCL/SDA pins into byte events: start or repeated start (with the direction of the transfer that follows), stop, one received byte, or a request for one byte to transmit. The block answers each received byte with an ACK or NAK. It answers each read request with a data byte. It also holds the register file and its power-up values.

The register map has two widths. Most locations hold one byte. Two locations hold a 32-bit word that is written and read most significant byte first. A 32-bit word changes only when all four of its bytes arrive in one burst. The first three bytes wait in a staging buffer, and the fourth byte moves the whole word into the live register in one step. Each committed write also goes out on a one-cycle configuration strobe (address plus zero-extended data), so the audio datapath can follow the change. A write to an address that does not exist is refused, and a one-cycle fault flag marks the refusal.

A register is read by writing its address and then, after a repeated start, reading as many bytes as the register is wide. Transfers never advance the address on their own.

Top module: `mixreg_i2c_target`

## Requirements
- R1: After reset, reads return these defaults: 0x00=0x6C, 0x03=0xA0, 0x04=0x05, 0x05=0x60, 0x07=0xFF, 0x08..0x0D=0x30, 0x18=0x3F, 0x1A=0x18, 0x1B=0x82, 0x1C=0x05, 0x20=0x00000000, 0x25=0x00000000. Every other accessible byte location reads 0x00.
- R2: A write to a one-byte location has two bytes: the address, then one data byte. Both bytes are ACKed and the new value can be read back. In the cycle that the data byte's ACK is reported, cfg_we pulses with cfg_addr equal to the address and cfg_data equal to the byte zero-extended.
- R3: The two four-byte locations, 0x20 and 0x25, take four data bytes, most significant first, and all four are ACKed. Only the fourth byte updates the register. It also gives a single cfg_we pulse that carries the full 32-bit word.
- R4: A burst to a four-byte location that ends (stop or new start) before its fourth data byte leaves that register unchanged and gives no cfg_we pulse.
- R5: An address byte is NAKed if it names an inaccessible location (0x0F, 0x11..0x17, 0x1D..0x1F, 0x21..0x24) or any address above 0x25. addr_fault pulses together with that NAK. Every data byte after it in the same transfer is NAKed and written nowhere.
- R6: A data byte beyond the width of the addressed register is NAKed and discarded. The address does not advance, so the next location keeps its value.
- R7: After an address write, a repeated-start read returns the register's bytes most significant first. Any byte requested past the register's width, or after a refused address, reads 0xFF.
- R8: Location 0x01 is read-only and always reads 0x03. Its address byte is ACKed, but its data bytes are NAKed.
- R9: Location 0x02 reads the live value of the err_in input. A data byte written to it is ACKed, but it changes nothing and gives no cfg_we pulse.
- R10: Driving rst_n low at any time returns every register to its R1 default.
- R11: ack_valid follows each received byte, and rd_valid follows each read request, exactly one clock later, each for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously inside the block |
| bus_start | input | 1 | Start or repeated start seen |
| bus_rd | input | 1 | Direction of the transfer after this start: 1 read, 0 write |
| bus_stop | input | 1 | Stop seen |
| wr_valid | input | 1 | A byte has been received from the controller |
| wr_byte | input | 8 | The received byte |
| rd_req | input | 1 | The bit engine asks for the next byte to transmit |
| err_in | input | 8 | Live error status, readable at location 0x02 |
| ack_valid | output | 1 | Response to the received byte is valid |
| ack | output | 1 | 1 ACK, 0 NAK |
| rd_valid | output | 1 | rd_byte is valid |
| rd_byte | output | 8 | Byte to transmit |
| addr_fault | output | 1 | One-cycle flag: an address byte was refused |
| cfg_we | output | 1 | One-cycle strobe of a committed register write |
| cfg_addr | output | 8 | Address of the committed register |
| cfg_data | output | 32 | Committed value, zero-extended for one-byte locations |

## Verification
All results of this block are registered once. ack, addr_fault and the cfg strobe for a received byte, and rd_byte for a read request, appear at the first rising edge after the request. They stay for exactly that one cycle. The bench drives each request at a falling edge, removes it at the next falling edge, and samples the responses at that same moment, which is half a cycle after they changed. Register contents are checked only through later read transfers. cfg_we pulses are counted at falling edges, so a missing or extra commit shows up as a wrong count.

// File: rtl/mixreg_pkg.sv
`timescale 1ns/1ps
package mixreg_pkg;

  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int WORD_W     = 32;
  localparam int NARROW_N   = 29;                 // one-byte locations 0x00..0x1C
  localparam int WIDE_N     = 2;                  // four-byte locations
  localparam int WIDE_BYTES = WORD_W / BYTE_W;
  localparam int STAGE_W    = WORD_W - BYTE_W;
  localparam int CNT_W      = $clog2(WIDE_BYTES + 1);
  localparam int NIDX_W     = $clog2(NARROW_N);
  localparam int WSEL_W     = (WIDE_N > 1) ? $clog2(WIDE_N) : 1;

  localparam logic [ADDR_W-1:0] LAST_NARROW = ADDR_W'(NARROW_N - 1);
  localparam logic [ADDR_W-1:0] ID_ADDR     = 8'h01;
  localparam logic [ADDR_W-1:0] ERR_ADDR    = 8'h02;
  localparam logic [BYTE_W-1:0] ID_VALUE    = 8'h03;
  localparam logic [BYTE_W-1:0] FILL_BYTE   = 8'hFF;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_DROP, SQ_READ
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] wide_addr(input int i);
    return (i == 0) ? 8'h20 : 8'h25;
  endfunction

  function automatic logic narrow_present(input logic [ADDR_W-1:0] a);
    return (a <= LAST_NARROW) && (a != 8'h0F) && !((a >= 8'h11) && (a <= 8'h17));
  endfunction

  function automatic logic [BYTE_W-1:0] narrow_default(input int i);
    logic [BYTE_W-1:0] v;
    case (i)
      0:                   v = 8'h6C;
      1:                   v = ID_VALUE;
      3:                   v = 8'hA0;
      4:                   v = 8'h05;
      5:                   v = 8'h60;
      7:                   v = 8'hFF;
      8, 9, 10, 11, 12, 13: v = 8'h30;
      24:                  v = 8'h3F;
      26:                  v = 8'h18;
      27:                  v = 8'h82;
      28:                  v = 8'h05;
      default:             v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mixreg_decode.sv
`timescale 1ns/1ps
module mixreg_decode
  import mixreg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_wide,
  output logic              can_write,
  output logic [WSEL_W-1:0] wsel,
  output logic [NIDX_W-1:0] nidx
);

  logic [WIDE_N-1:0] wide_hit;

  for (genvar g = 0; g < WIDE_N; g++) begin : g_wide_match
    assign wide_hit[g] = (addr == wide_addr(g));
  end

  always_comb begin
    hit       = 1'b0;
    is_wide   = 1'b0;
    can_write = 1'b0;
    wsel      = '0;
    nidx      = addr[NIDX_W-1:0];
    if (narrow_present(addr)) begin
      hit       = 1'b1;
      can_write = (addr != ID_ADDR);
    end
    for (int i = 0; i < WIDE_N; i++) begin
      if (wide_hit[i]) begin
        hit       = 1'b1;
        is_wide   = 1'b1;
        can_write = 1'b1;
        wsel      = WSEL_W'(i);
      end
    end
  end

endmodule

// File: rtl/mixreg_store.sv
`timescale 1ns/1ps
module mixreg_store
  import mixreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_we,
  input  logic              w_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sel_wide,
  input  logic [WSEL_W-1:0] sel_w,
  input  logic [NIDX_W-1:0] sel_n,
  output logic [WORD_W-1:0] rd_word
);

  logic [BYTE_W-1:0] narrow_q [NARROW_N];
  logic [WORD_W-1:0] wide_q   [WIDE_N];

  for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
    logic              en;
    logic [BYTE_W-1:0] nxt;
    always_comb begin
      en  = n_we && (sel_n == NIDX_W'(g));
      nxt = en ? wdata[BYTE_W-1:0] : narrow_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) narrow_q[g] <= narrow_default(g);
      else        narrow_q[g] <= nxt;
    end
  end

  for (genvar g = 0; g < WIDE_N; g++) begin : g_wide
    logic              en;
    logic [WORD_W-1:0] nxt;
    always_comb begin
      en  = w_we && (sel_w == WSEL_W'(g));
      nxt = en ? wdata : wide_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wide_q[g] <= '0;
      else        wide_q[g] <= nxt;
    end

    // R4
    wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_we && (sel_w == WSEL_W'(g))) |=> $stable(wide_q[g]));
  end

  always_comb begin
    rd_word = '0;
    if (sel_wide) begin
      for (int i = 0; i < WIDE_N; i++)
        if (sel_w == WSEL_W'(i)) rd_word = wide_q[i];
    end else begin
      for (int i = 0; i < NARROW_N; i++)
        if (sel_n == NIDX_W'(i)) rd_word = {{(WORD_W-BYTE_W){1'b0}}, narrow_q[i]};
    end
  end

endmodule

// File: rtl/mixreg_seq.sv
`timescale 1ns/1ps
module mixreg_seq
  import mixreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_rd,
  input  logic              bus_stop,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_req,
  input  logic [BYTE_W-1:0] err_in,
  output logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_hit,
  input  logic              dec_wide,
  input  logic              dec_wr_ok,
  input  logic [WORD_W-1:0] rd_word,
  output logic              n_we,
  output logic              w_we,
  output logic [WORD_W-1:0] wdata,
  output logic              ack_valid,
  output logic              ack,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              addr_fault,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [WORD_W-1:0] cfg_data
);

  seq_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               aok_q, aok_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic               ackv_q, ackv_d, ack_q, ack_d;
  logic               rdv_q, rdv_d;
  logic [BYTE_W-1:0]  rdb_q, rdb_d;
  logic               flt_q, flt_d;
  logic               cwe_q, cwe_d;
  logic [ADDR_W-1:0]  cad_q, cad_d;
  logic [WORD_W-1:0]  cdt_q, cdt_d;
  logic [CNT_W-1:0]   reg_len;
  logic [BYTE_W-1:0]  pick_byte;

  assign dec_addr = (state_q == SQ_ADDR) ? wr_byte : addr_q;
  assign reg_len  = dec_wide ? CNT_W'(WIDE_BYTES) : CNT_W'(1);

  always_comb begin
    pick_byte = rd_word[BYTE_W-1:0];
    if (addr_q == ERR_ADDR) begin
      pick_byte = err_in;
    end else if (dec_wide) begin
      for (int i = 0; i < WIDE_BYTES; i++)
        if (cnt_q == CNT_W'(i)) pick_byte = rd_word[WORD_W-1-BYTE_W*i -: BYTE_W];
    end
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    aok_d   = aok_q;
    cnt_d   = cnt_q;
    stage_d = stage_q;
    ackv_d  = 1'b0;
    ack_d   = 1'b0;
    rdv_d   = 1'b0;
    rdb_d   = rdb_q;
    flt_d   = 1'b0;
    cwe_d   = 1'b0;
    cad_d   = cad_q;
    cdt_d   = cdt_q;
    n_we    = 1'b0;
    w_we    = 1'b0;
    wdata   = {stage_q, wr_byte};
    if (bus_start) begin
      state_d = bus_rd ? SQ_READ : SQ_ADDR;
      cnt_d   = '0;
    end else if (bus_stop) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
    end else begin
      if (wr_valid) begin
        ackv_d = 1'b1;
        case (state_q)
          SQ_ADDR: begin
            if (dec_hit) begin
              addr_d  = wr_byte;
              aok_d   = 1'b1;
              ack_d   = 1'b1;
              cnt_d   = '0;
              state_d = SQ_DATA;
            end else begin
              aok_d   = 1'b0;
              flt_d   = 1'b1;
              state_d = SQ_DROP;
            end
          end
          SQ_DATA: begin
            if ((cnt_q < reg_len) && dec_wr_ok) begin
              ack_d = 1'b1;
              cnt_d = cnt_q + CNT_W'(1);
              if (!dec_wide) begin
                if (addr_q != ERR_ADDR) begin
                  wdata = {{(WORD_W-BYTE_W){1'b0}}, wr_byte};
                  n_we  = 1'b1;
                  cwe_d = 1'b1;
                  cad_d = addr_q;
                  cdt_d = wdata;
                end
              end else if (cnt_q == CNT_W'(WIDE_BYTES - 1)) begin
                w_we  = 1'b1;
                cwe_d = 1'b1;
                cad_d = addr_q;
                cdt_d = wdata;
              end else begin
                stage_d = {stage_q[STAGE_W-BYTE_W-1:0], wr_byte};
              end
            end else begin
              state_d = SQ_DROP;
            end
          end
          default: ack_d = 1'b0;
        endcase
      end
      if (rd_req) begin
        rdv_d = 1'b1;
        rdb_d = FILL_BYTE;
        if ((state_q == SQ_READ) && aok_q && (cnt_q < reg_len)) begin
          rdb_d = pick_byte;
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      aok_q   <= 1'b0;
      cnt_q   <= '0;
      stage_q <= '0;
      ackv_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdb_q   <= '0;
      flt_q   <= 1'b0;
      cwe_q   <= 1'b0;
      cad_q   <= '0;
      cdt_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      aok_q   <= aok_d;
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      ackv_q  <= ackv_d;
      ack_q   <= ack_d;
      rdv_q   <= rdv_d;
      rdb_q   <= rdb_d;
      flt_q   <= flt_d;
      cwe_q   <= cwe_d;
      cad_q   <= cad_d;
      cdt_q   <= cdt_d;
    end
  end

  assign ack_valid  = ackv_q;
  assign ack        = ack_q;
  assign rd_valid   = rdv_q;
  assign rd_byte    = rdb_q;
  assign addr_fault = flt_q;
  assign cfg_we     = cwe_q;
  assign cfg_addr   = cad_q;
  assign cfg_data   = cdt_q;

  // R11
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !bus_start && !bus_stop) |=> ack_valid);

  // R11
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_start && !bus_stop) |=> rd_valid);

  // R5
  fault_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |-> (ack_valid && !ack));

  // R2
  cfg_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (ack_valid && ack));

  // R6
  drop_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DROP && wr_valid && !bus_start && !bus_stop) |=> !ack);

endmodule

// File: rtl/mixreg_i2c_target.sv
`timescale 1ns/1ps
module mixreg_i2c_target
  import mixreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_start,
  input  logic        bus_rd,
  input  logic        bus_stop,
  input  logic        wr_valid,
  input  logic [7:0]  wr_byte,
  input  logic        rd_req,
  input  logic [7:0]  err_in,
  output logic        ack_valid,
  output logic        ack,
  output logic        rd_valid,
  output logic [7:0]  rd_byte,
  output logic        addr_fault,
  output logic        cfg_we,
  output logic [7:0]  cfg_addr,
  output logic [31:0] cfg_data
);

  logic              rst_meta, rst_sync;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_hit, dec_wide, dec_wr_ok;
  logic [WSEL_W-1:0] dec_wsel;
  logic [NIDX_W-1:0] dec_nidx;
  logic              n_we, w_we;
  logic [WORD_W-1:0] wdata, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  mixreg_decode u_decode (
    .addr      (dec_addr),
    .hit       (dec_hit),
    .is_wide   (dec_wide),
    .can_write (dec_wr_ok),
    .wsel      (dec_wsel),
    .nidx      (dec_nidx)
  );

  mixreg_store u_store (
    .clk      (clk),
    .rst_n    (rst_sync),
    .n_we     (n_we),
    .w_we     (w_we),
    .wdata    (wdata),
    .sel_wide (dec_wide),
    .sel_w    (dec_wsel),
    .sel_n    (dec_nidx),
    .rd_word  (rd_word)
  );

  mixreg_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .bus_start  (bus_start),
    .bus_rd     (bus_rd),
    .bus_stop   (bus_stop),
    .wr_valid   (wr_valid),
    .wr_byte    (wr_byte),
    .rd_req     (rd_req),
    .err_in     (err_in),
    .dec_addr   (dec_addr),
    .dec_hit    (dec_hit),
    .dec_wide   (dec_wide),
    .dec_wr_ok  (dec_wr_ok),
    .rd_word    (rd_word),
    .n_we       (n_we),
    .w_we       (w_we),
    .wdata      (wdata),
    .ack_valid  (ack_valid),
    .ack        (ack),
    .rd_valid   (rd_valid),
    .rd_byte    (rd_byte),
    .addr_fault (addr_fault),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(rst_sync) |-> (!cfg_we && !ack_valid && !rd_valid));

endmodule

// File: tb/mixreg_i2c_target_bench.sv
`timescale 1ns/1ps
module mixreg_i2c_target_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_start, bus_rd, bus_stop, wr_valid, rd_req;
  logic [7:0]  wr_byte, err_in;
  logic        ack_valid, ack, rd_valid, addr_fault, cfg_we;
  logic [7:0]  rd_byte, cfg_addr;
  logic [31:0] cfg_data;

  int n_vec = 0;
  int n_bad = 0;
  int cfg_cnt = 0;
  bit done = 0;

  logic        last_fault, last_cfg;
  logic [7:0]  last_cfg_a;
  logic [31:0] last_cfg_d;

  always #5 clk = ~clk;

  mixreg_i2c_target u_mixreg_i2c_target (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rd(bus_rd),
    .bus_stop(bus_stop), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .rd_req(rd_req), .err_in(err_in), .ack_valid(ack_valid), .ack(ack),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .addr_fault(addr_fault),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  always @(negedge clk) if (rst_n && cfg_we) cfg_cnt++;

  // {is_write, address, value}
  localparam logic [40:0] VEC [0:13] = '{
    {1'b0, 8'h00, 32'h0000006C},
    {1'b0, 8'h03, 32'h000000A0},
    {1'b0, 8'h07, 32'h000000FF},
    {1'b0, 8'h0D, 32'h00000030},
    {1'b0, 8'h1B, 32'h00000082},
    {1'b0, 8'h1C, 32'h00000005},
    {1'b0, 8'h20, 32'h00000000},
    {1'b0, 8'h01, 32'h00000003},
    {1'b1, 8'h07, 32'h0000005A},
    {1'b1, 8'h20, 32'hDEADBEEF},
    {1'b1, 8'h25, 32'h01234567},
    {1'b1, 8'h1A, 32'h000000C3},
    {1'b1, 8'h10, 32'h0000007E},
    {1'b0, 8'h18, 32'h0000003F}
  };

  function automatic int blen(input logic [7:0] a);
    return (a >= 8'h20) ? 4 : 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_begin(input logic rd);
    @(negedge clk); bus_start = 1'b1; bus_rd = rd;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic bus_end;
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    @(negedge clk); wr_valid = 1'b1; wr_byte = b;
    @(negedge clk); wr_valid = 1'b0;
    acked      = ack_valid && ack;
    last_fault = addr_fault;
    last_cfg   = cfg_we;
    last_cfg_a = cfg_addr;
    last_cfg_d = cfg_data;
  endtask

  task automatic get_byte(output logic [7:0] b);
    @(negedge clk); rd_req = 1'b1;
    check("R11 rd_valid idle before request", {31'b0, rd_valid}, 32'd0);
    @(negedge clk); rd_req = 1'b0;
    check("R11 rd_valid one cycle after request", {31'b0, rd_valid}, 32'd1);
    b = rd_byte;
  endtask

  task automatic reg_read(input logic [7:0] a, input int n, output logic [31:0] v);
    logic ak;
    logic [7:0] b;
    v = '0;
    bus_begin(1'b0);
    send_byte(a, ak);
    bus_begin(1'b1);
    for (int i = 0; i < n; i++) begin
      get_byte(b);
      v = {v[23:0], b};
    end
    bus_end();
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] v, input int n,
                           output logic aack, output logic [3:0] dack);
    logic ak;
    dack = '0;
    bus_begin(1'b0);
    send_byte(a, aack);
    for (int i = 0; i < n; i++) begin
      send_byte(v[31-8*(4-n+i) -: 8], ak);
      dack[i] = ak;
    end
    bus_end();
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic        aack;
    logic [3:0]  dack;
    int          c0;
    rst_n = 1'b0; bus_start = 0; bus_rd = 0; bus_stop = 0;
    wr_valid = 0; wr_byte = 0; rd_req = 0; err_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs quiet after reset", {28'b0, ack_valid, rd_valid, cfg_we, addr_fault}, 32'd0);

    // vector table: R1 and R8 reads, R2 and R3 writes
    for (int k = 0; k < 14; k++) begin
      logic [7:0]  a;
      logic [31:0] val;
      a   = VEC[k][39:32];
      val = VEC[k][31:0];
      if (VEC[k][40]) begin
        reg_write(a, val, blen(a), aack, dack);
        check("R2/R3 address ack", {31'b0, aack}, 32'd1);
        check("R2/R3 data acks", {28'b0, dack}, (blen(a) == 4) ? 32'hF : 32'h1);
        check("R2/R3 cfg strobe on last byte", {23'b0, last_cfg, last_cfg_a}, {23'b0, 1'b1, a});
        check("R2/R3 cfg data", last_cfg_d, val);
      end
      reg_read(a, blen(a), v);
      check((a >= 8'h20) ? "R3/R1 readback" : "R2/R1 readback", v, val);
    end

    // R3: only the fourth byte commits, exactly one strobe
    c0 = cfg_cnt;
    reg_write(8'h20, 32'hA1B2C3D4, 4, aack, dack);
    check("R3 one cfg pulse per wide burst", cfg_cnt - c0, 32'd1);

    // R4: partial wide burst
    c0 = cfg_cnt;
    reg_write(8'h25, 32'h00009988, 2, aack, dack);
    check("R4 partial bytes acked", {28'b0, dack}, 32'h3);
    check("R4 no cfg pulse", cfg_cnt - c0, 32'd0);
    reg_read(8'h25, 4, v);
    check("R4 wide register unchanged", v, 32'h01234567);

    // R5: illegal addresses
    c0 = cfg_cnt;
    reg_write(8'h0F, 32'h00000055, 1, aack, dack);
    check("R5 0x0F address nak", {31'b0, aack}, 32'd0);
    check("R5 data after bad address nak", {28'b0, dack}, 32'd0);
    bus_begin(1'b0); send_byte(8'h22, aack); bus_end();
    check("R5 0x22 nak with fault", {30'b0, aack, last_fault}, 32'd1);
    bus_begin(1'b0); send_byte(8'h40, aack); bus_end();
    check("R5 0x40 nak with fault", {30'b0, aack, last_fault}, 32'd1);
    check("R5 no cfg pulse", cfg_cnt - c0, 32'd0);
    reg_read(8'h0F, 1, v);
    check("R7 read after refused address is fill", v, 32'h000000FF);

    // R6: no auto-increment
    reg_write(8'h08, 32'h00001122, 2, aack, dack);
    check("R6 extra byte nak", {28'b0, dack}, 32'h1);
    reg_read(8'h08, 1, v);
    check("R6 target holds first byte", v, 32'h00000011);
    reg_read(8'h09, 1, v);
    check("R6 next location untouched", v, 32'h00000030);

    // R7: read past width
    reg_read(8'h1A, 2, v);
    check("R7 over-read returns fill", v, 32'h0000C3FF);

    // R8: read-only identity
    reg_write(8'h01, 32'h00000077, 1, aack, dack);
    check("R8 id address ack, data nak", {30'b0, aack, dack[0]}, 32'h2);
    reg_read(8'h01, 1, v);
    check("R8 id still 0x03", v, 32'h00000003);

    // R9: live error status
    err_in = 8'hA5;
    reg_read(8'h02, 1, v);
    check("R9 err reads input", v, 32'h000000A5);
    c0 = cfg_cnt;
    reg_write(8'h02, 32'h00000011, 1, aack, dack);
    check("R9 err write acked", {30'b0, aack, dack[0]}, 32'h3);
    check("R9 err write no cfg pulse", cfg_cnt - c0, 32'd0);
    err_in = 8'h3C;
    reg_read(8'h02, 1, v);
    check("R9 err follows input", v, 32'h0000003C);

    // R10: reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(8'h07, 1, v);
    check("R10 narrow default restored", v, 32'h000000FF);
    reg_read(8'h20, 4, v);
    check("R10 wide default restored", v, 32'h00000000);
    reg_read(8'h10, 1, v);
    check("R10 zero default restored", v, 32'h00000000);

    finish_run();
  end

endmodule